// File: doc/BRIEF.md
# Decoded Pattern Matcher

This block watches a stream of bytes and raises a flag whenever the stream completes one of a fixed set of search strings. The strings are chosen when the design is elaborated and cannot change at run time. Each incoming byte is compared once against every distinct character that appears anywhere in the string set, which gives one equality wire per character. Those single-bit results are delayed in short shift registers and ANDed together, so one match gate per string fires on the byte that completes it.

Delayed bits are shared. Any two strings that need the same character at the same distance from the end of a segment read the same delay line. Strings longer than the segment limit (16 characters by default) are cut into consecutive segments. The hit of one segment is delayed by the length of the next segment and enters that segment's AND gate as one more input. The hit of the last segment is the string's match.

A producer presents bytes with a valid strobe. Invalid cycles are skipped: all history is frozen, so a string may straddle gaps in the stream. The match vector carries one bit per string. It is a one-cycle pulse, and it appears a fixed two cycles after the completing byte is presented, for every string.

Top module: `decoded_pattern_matcher`

## Requirements
- R1: Bit p of `matchOut` is 1 for exactly one cycle, two rising edges after the byte that completes string p is presented with `inValid` high, and 0 otherwise. The latency is the same for every string. The default set is: bit 0 "ABCA", bit 1 "CAB", bit 2 "HELLO_WORLD_ATTACK!!", bit 3 "Z". Each string's first character is the one that arrives first.
- R2: Overlapping occurrences are each reported. The valid stream ABCABCA raises bit 0 on the 4th byte and again on the 7th.
- R3: A byte presented with `inValid` low is ignored. It produces an all-zero `matchOut` two edges later and leaves the stored history unchanged, so a string split by invalid cycles still matches on its final valid byte.
- R4: A string longer than 16 characters matches only when all of its segments appear back to back in consecutive valid bytes. A wrong character in any segment, or an extra valid byte between segments, gives no match.
- R5: While `rst` is high at a rising edge, all history and `matchOut` are cleared. After reset, no string is reported until all of its characters have arrived as valid bytes after reset.
- R6: Strings that share characters are matched independently, each on its own bit. The stream ...ABCAB raises bit 1 on its final B without raising bit 0.
- R7: A one-character string matches on every valid occurrence of that character, with no earlier history needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | High when `inByte` carries a stream byte |
| inByte | input | 8 | Stream byte |
| matchOut | output | NUM_PAT | One match pulse bit per string, bit p for string p |

## Verification
A stuck or lost bit in a character delay line appears as a missing or spurious pulse on the string's bit, two cycles after the byte that should or should not complete it. A bit that changes during an invalid cycle appears as a missed match on the first string that crosses a gap. A wrong segment-carry delay on the long string shows up on a single byte: either the good stream fails to fire, or the stream with a byte inserted between segments fires. History that survives reset is exposed by the first partial string sent after reset.

// File: rtl/pm_pkg.sv
`timescale 1ns/1ps
package pm_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic shiftEn;   // advance every delay line by one stream byte
    logic clearAll;  // synchronous clear of all history and outputs
  } pmStrobe_t;

  localparam int DEF_NUM_PAT = 4;
  localparam int DEF_MAX_LEN = 20;
  localparam int DEF_LEN_W   = 8;

  // Each string sits in its own MAX_LEN-byte slot, right aligned:
  // the last character of a string is the lowest byte of its slot.
  localparam logic [DEF_NUM_PAT*DEF_MAX_LEN*8-1:0] DEF_TEXT = {
    160'("Z"),
    160'("HELLO_WORLD_ATTACK!!"),
    160'("CAB"),
    160'("ABCA")
  };

  localparam logic [DEF_NUM_PAT*DEF_LEN_W-1:0] DEF_LENS = {8'd1, 8'd20, 8'd3, 8'd4};

endpackage

// File: rtl/pm_ctrl.sv
`timescale 1ns/1ps
module pm_ctrl
  import pm_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      inValid,
  output pmStrobe_t strobe
);

  logic validQ;

  always_ff @(posedge clk) begin
    if (rst) validQ <= 1'b0;
    else     validQ <= inValid;
  end

  assign strobe.shiftEn  = validQ;
  assign strobe.clearAll = rst;

endmodule

// File: rtl/pm_datapath.sv
`timescale 1ns/1ps
module pm_datapath
  import pm_pkg::*;
#(
  parameter int NUM_PAT = DEF_NUM_PAT,
  parameter int MAX_LEN = DEF_MAX_LEN,
  parameter int LEN_W   = DEF_LEN_W,
  parameter int SUB_LEN = 16,
  parameter logic [NUM_PAT*MAX_LEN*8-1:0] PAT_TEXT = DEF_TEXT,
  parameter logic [NUM_PAT*LEN_W-1:0]     PAT_LEN  = DEF_LENS
)(
  input  logic               clk,
  input  pmStrobe_t          strobe,
  input  logic [7:0]         inByte,
  output logic [NUM_PAT-1:0] matchOut
);

  localparam int NUM_SLOTS = NUM_PAT * MAX_LEN;
  localparam int MAX_SUB   = (MAX_LEN + SUB_LEN - 1) / SUB_LEN;

  // ---------------- elaboration-time helpers ----------------
  function automatic int lenOf(input int p);
    return int'(PAT_LEN[p*LEN_W +: LEN_W]);
  endfunction

  function automatic bit usedSlot(input int s);
    return (s % MAX_LEN) < lenOf(s / MAX_LEN);
  endfunction

  // character at arrival position i of string p (slot s = p*MAX_LEN+i)
  function automatic logic [7:0] charOf(input int s);
    int p;
    int i;
    p = s / MAX_LEN;
    i = s % MAX_LEN;
    if (i >= lenOf(p)) return 8'd0;
    return PAT_TEXT[(p*MAX_LEN + lenOf(p) - 1 - i)*8 +: 8];
  endfunction

  function automatic int subLenOf(input int p, input int j);
    int r;
    r = lenOf(p) - j*SUB_LEN;
    if (r > SUB_LEN) return SUB_LEN;
    if (r < 0) return 0;
    return r;
  endfunction

  function automatic int nSubOf(input int p);
    return (lenOf(p) + SUB_LEN - 1) / SUB_LEN;
  endfunction

  // cycles a character bit waits before meeting its segment's last byte
  function automatic int distOf(input int s);
    int p;
    int i;
    p = s / MAX_LEN;
    i = s % MAX_LEN;
    return subLenOf(p, i / SUB_LEN) - 1 - (i % SUB_LEN);
  endfunction

  // sharing key: character alone, or character plus delay
  function automatic logic [15:0] keyOf(input int s, input bit withDist);
    logic [15:0] k;
    k = {8'd0, charOf(s)};
    if (withDist) k[15:8] = 8'(distOf(s));
    return k;
  endfunction

  function automatic int firstOf(input int s, input bit withDist);
    int r;
    r = s;
    for (int t = s - 1; t >= 0; t--)
      if (usedSlot(t) && keyOf(t, withDist) == keyOf(s, withDist)) r = t;
    return r;
  endfunction

  function automatic int idOf(input int s, input bit withDist);
    int n;
    int f;
    n = 0;
    f = firstOf(s, withDist);
    for (int t = 0; t < f; t++)
      if (usedSlot(t) && firstOf(t, withDist) == t) n++;
    return n;
  endfunction

  function automatic int countKeys(input bit withDist);
    int n;
    n = 0;
    for (int t = 0; t < NUM_SLOTS; t++)
      if (usedSlot(t) && firstOf(t, withDist) == t) n++;
    return n;
  endfunction

  function automatic int slotOfId(input int k, input bit withDist);
    int n;
    int r;
    n = 0;
    r = 0;
    for (int t = 0; t < NUM_SLOTS; t++)
      if (usedSlot(t) && firstOf(t, withDist) == t) begin
        if (n == k) r = t;
        n++;
      end
    return r;
  endfunction

  localparam int NUM_CHARS = countKeys(1'b0);
  localparam int NUM_TAPS  = countKeys(1'b1);

  // ---------------- input byte and shared decoders ----------------
  logic [7:0]           byteQ;
  logic [NUM_CHARS-1:0] cmpHit;
  logic [NUM_TAPS-1:0]  tapOut;
  logic [NUM_PAT-1:0]   matchD;

  always_ff @(posedge clk) begin
    if (strobe.clearAll) byteQ <= 8'd0;
    else                 byteQ <= inByte;
  end

  for (genvar k = 0; k < NUM_CHARS; k++) begin : g_char
    localparam logic [7:0] CH = charOf(slotOfId(k, 1'b0));
    assign cmpHit[k] = (byteQ == CH);
  end

  // ---------------- shared single-bit delay lines ----------------
  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
    localparam int SL = slotOfId(k, 1'b1);
    localparam int D  = distOf(SL);
    localparam int CI = idOf(SL, 1'b0);
    if (D == 0) begin : g_direct
      assign tapOut[k] = cmpHit[CI];
    end else if (D == 1) begin : g_one
      logic line;
      always_ff @(posedge clk) begin
        if (strobe.clearAll)    line <= 1'b0;
        else if (strobe.shiftEn) line <= cmpHit[CI];
      end
      assign tapOut[k] = line;
    end else begin : g_multi
      logic [D-1:0] line;
      always_ff @(posedge clk) begin
        if (strobe.clearAll)    line <= '0;
        else if (strobe.shiftEn) line <= {line[D-2:0], cmpHit[CI]};
      end
      assign tapOut[k] = line[D-1];
    end
  end

  // ---------------- per-string segment AND trees ----------------
  for (genvar p = 0; p < NUM_PAT; p++) begin : g_pat
    localparam int L  = lenOf(p);
    localparam int NS = nSubOf(p);
    localparam logic [MAX_SUB-1:0] LAST = MAX_SUB'(1) << (NS - 1);
    logic [MAX_SUB-1:0] hit;
    logic [MAX_SUB-1:0] carry;

    assign carry[0] = 1'b1;

    for (genvar j = 0; j < MAX_SUB; j++) begin : g_sub
      logic [SUB_LEN-1:0] need;
      for (genvar li = 0; li < SUB_LEN; li++) begin : g_pos
        localparam int I = j*SUB_LEN + li;
        if (I < L) begin : g_real
          localparam int TID = idOf(p*MAX_LEN + I, 1'b1);
          assign need[li] = tapOut[TID];
        end else begin : g_pad
          assign need[li] = 1'b1;
        end
      end
      assign hit[j] = (&need) & carry[j];

      if (j + 1 < MAX_SUB) begin : g_link
        localparam int NL = subLenOf(p, j + 1);
        if (NL == 0) begin : g_none
          assign carry[j+1] = 1'b0;
        end else if (NL == 1) begin : g_one
          logic partLine;
          always_ff @(posedge clk) begin
            if (strobe.clearAll)    partLine <= 1'b0;
            else if (strobe.shiftEn) partLine <= hit[j];
          end
          assign carry[j+1] = partLine;
        end else begin : g_multi
          logic [NL-1:0] partLine;
          always_ff @(posedge clk) begin
            if (strobe.clearAll)    partLine <= '0;
            else if (strobe.shiftEn) partLine <= {partLine[NL-2:0], hit[j]};
          end
          assign carry[j+1] = partLine[NL-1];
        end
      end
    end

    assign matchD[p] = |(hit & LAST);
  end

  // ---------------- output register ----------------
  always_ff @(posedge clk) begin
    if (strobe.clearAll)    matchOut <= '0;
    else if (strobe.shiftEn) matchOut <= matchD;
    else                    matchOut <= '0;
  end

endmodule

// File: rtl/decoded_pattern_matcher.sv
`timescale 1ns/1ps
module decoded_pattern_matcher
  import pm_pkg::*;
#(
  parameter int NUM_PAT = DEF_NUM_PAT,
  parameter int MAX_LEN = DEF_MAX_LEN,
  parameter int LEN_W   = DEF_LEN_W,
  parameter int SUB_LEN = 16,
  parameter logic [NUM_PAT*MAX_LEN*8-1:0] PAT_TEXT = DEF_TEXT,
  parameter logic [NUM_PAT*LEN_W-1:0]     PAT_LEN  = DEF_LENS
)(
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  input  logic [7:0]         inByte,
  output logic [NUM_PAT-1:0] matchOut
);

  pmStrobe_t strobe;

  pm_ctrl ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .strobe  (strobe)
  );

  pm_datapath #(
    .NUM_PAT  (NUM_PAT),
    .MAX_LEN  (MAX_LEN),
    .LEN_W    (LEN_W),
    .SUB_LEN  (SUB_LEN),
    .PAT_TEXT (PAT_TEXT),
    .PAT_LEN  (PAT_LEN)
  ) dp_i (
    .clk      (clk),
    .strobe   (strobe),
    .inByte   (inByte),
    .matchOut (matchOut)
  );

endmodule

// File: rtl/pm_checker.sv
`timescale 1ns/1ps
module pm_checker #(
  parameter int NUM_PAT = 4,
  parameter int MAX_LEN = 20,
  parameter int LEN_W   = 8,
  parameter logic [NUM_PAT*MAX_LEN*8-1:0] PAT_TEXT = '0,
  parameter logic [NUM_PAT*LEN_W-1:0]     PAT_LEN  = '0
)(
  input logic               clk,
  input logic               rst,
  input logic               inValid,
  input logic [7:0]         inByte,
  input logic [NUM_PAT-1:0] matchOut
);

  localparam int CNT_W = $clog2(MAX_LEN + 1) + 1;

  logic [1:0]       age;
  logic [CNT_W-1:0] validCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      age      <= '0;
      validCnt <= '0;
    end else begin
      if (age != 2'd3) age <= age + 2'd1;
      if (inValid && validCnt < CNT_W'(MAX_LEN)) validCnt <= validCnt + 1'b1;
    end
  end

  // R5
  reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (matchOut == '0));

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3 && !$past(inValid, 2)) |-> (matchOut == '0));

  for (genvar p = 0; p < NUM_PAT; p++) begin : g_pchk
    localparam logic [7:0] LASTCH = PAT_TEXT[p*MAX_LEN*8 +: 8];
    localparam int         PLEN   = int'(PAT_LEN[p*LEN_W +: LEN_W]);

    // R1
    last_char_chk: assert property (@(posedge clk) disable iff (rst)
      (age >= 2'd2 && matchOut[p]) |-> ($past(inValid, 2) && $past(inByte, 2) == LASTCH));

    // R5
    enough_bytes_chk: assert property (@(posedge clk) disable iff (rst)
      matchOut[p] |-> (validCnt >= CNT_W'(PLEN)));
  end

endmodule

bind decoded_pattern_matcher pm_checker #(
  .NUM_PAT  (NUM_PAT),
  .MAX_LEN  (MAX_LEN),
  .LEN_W    (LEN_W),
  .PAT_TEXT (PAT_TEXT),
  .PAT_LEN  (PAT_LEN)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .inByte   (inByte),
  .matchOut (matchOut)
);

// File: tb/decoded_pattern_matcher_tb_top.sv
`timescale 1ns/1ps
module decoded_pattern_matcher_tb_top;

  localparam int NP = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          inValid = 1'b0;
  logic [7:0]    inByte = 8'd0;
  logic [NP-1:0] matchOut;

  always #2 clk = ~clk;

  decoded_pattern_matcher dut_i (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .inByte   (inByte),
    .matchOut (matchOut)
  );

  int testsRun = 0;
  int testsFailed = 0;

  logic [NP-1:0] expPipe [2];
  bit            chkPipe [2];
  string         tagPipe [2];

  // {valid, byte, expected match vector for this byte, requirement id}
  localparam logic [15:0] VEC [16] = '{
    {1'b1, 8'h41, 4'b0000, 3'd1},  // A
    {1'b1, 8'h42, 4'b0000, 3'd1},  // B
    {1'b1, 8'h43, 4'b0000, 3'd1},  // C
    {1'b1, 8'h41, 4'b0001, 3'd2},  // A : ABCA
    {1'b1, 8'h42, 4'b0010, 3'd6},  // B : CAB only
    {1'b1, 8'h43, 4'b0000, 3'd2},  // C
    {1'b1, 8'h41, 4'b0001, 3'd2},  // A : overlapping ABCA
    {1'b1, 8'h5A, 4'b1000, 3'd7},  // Z
    {1'b0, 8'h42, 4'b0000, 3'd3},  // ignored
    {1'b1, 8'h43, 4'b0000, 3'd3},  // C
    {1'b0, 8'h58, 4'b0000, 3'd3},  // ignored
    {1'b1, 8'h41, 4'b0000, 3'd3},  // A
    {1'b1, 8'h42, 4'b0010, 3'd3},  // B : CAB across gaps
    {1'b0, 8'h5A, 4'b0000, 3'd3},  // ignored Z
    {1'b1, 8'h43, 4'b0000, 3'd3},  // C
    {1'b1, 8'h41, 4'b0001, 3'd3}   // A : ABCA across gap
  };

  function automatic string tagName(input int n);
    case (n)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: matchOut=%b expected %b", tag, act, exp);
    end
  endtask

  // Drive one byte; the result of a byte is checked two negedges later.
  task automatic step(input bit v, input logic [7:0] b, input logic [NP-1:0] exp,
                      input string tag, input bit chk = 1'b1);
    @(negedge clk);
    if (chkPipe[1]) check(tagPipe[1], matchOut, expPipe[1]);
    expPipe[1] = expPipe[0];
    chkPipe[1] = chkPipe[0];
    tagPipe[1] = tagPipe[0];
    expPipe[0] = exp;
    chkPipe[0] = chk;
    tagPipe[0] = tag;
    inValid = v;
    inByte  = b;
  endtask

  task automatic flush();
    step(1'b0, 8'h00, '0, "", 1'b0);
    step(1'b0, 8'h00, '0, "", 1'b0);
  endtask

  // Send a string; byte at index badIdx is replaced by badCh, and an
  // extra valid byte extraCh goes in front of index extraIdx (-1 disables).
  task automatic sendStr(input string s, input int badIdx, input logic [7:0] badCh,
                         input int extraIdx, input logic [NP-1:0] expLast, input string tag);
    for (int i = 0; i < s.len(); i++) begin
      logic [7:0] ch;
      if (i == extraIdx) step(1'b1, 8'h51, '0, tag);
      ch = (i == badIdx) ? badCh : 8'(s[i]);
      step(1'b1, ch, (i == s.len() - 1) ? expLast : '0, tag);
    end
  endtask

  initial begin
    #(4 * 200000);
    testsFailed++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2; i++) begin
      expPipe[i] = '0;
      chkPipe[i] = 1'b0;
      tagPipe[i] = "";
    end

    // R5: reset state
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R5", matchOut, '0);

    // Table walk: R1, R2, R3, R6, R7
    for (int k = 0; k < 16; k++) begin
      step(VEC[k][15], VEC[k][14:7], VEC[k][6:3], tagName(int'(VEC[k][2:0])));
    end
    flush();

    // R5: reset in the middle of a string erases history
    step(1'b1, 8'h41, '0, "R5");
    step(1'b1, 8'h42, '0, "R5");
    step(1'b1, 8'h43, '0, "R5");
    flush();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    step(1'b1, 8'h41, '0, "R5");        // would complete ABCA without reset
    step(1'b1, 8'h42, '0, "R5");
    step(1'b1, 8'h43, '0, "R5");
    step(1'b1, 8'h41, 4'b0001, "R5");   // fresh ABCA after reset
    flush();

    // R4: long string, two chained segments
    sendStr("HELLO_WORLD_ATTACK!!", -1, 8'h00, -1, 4'b0100, "R4");
    flush();
    sendStr("HELLO_WORLD_ATTACK!!", 17, 8'h58, -1, 4'b0000, "R4");  // bad in 2nd segment
    flush();
    sendStr("HELLO_WORLD_ATTACK!!", 1, 8'h58, -1, 4'b0000, "R4");   // bad in 1st segment
    flush();
    sendStr("HELLO_WORLD_ATTACK!!", -1, 8'h00, 16, 4'b0000, "R4");  // extra byte between
    flush();

    // R3 with R4: invalid gaps inside the long string, ignored Z bytes
    begin
      string s;
      s = "HELLO_WORLD_ATTACK!!";
      for (int i = 0; i < s.len(); i++) begin
        if (i == 8 || i == 16) step(1'b0, 8'h5A, '0, "R3");
        step(1'b1, 8'(s[i]), (i == s.len() - 1) ? 4'b0100 : 4'b0000, "R4");
      end
    end
    flush();

    // R7: consecutive single-character matches
    step(1'b1, 8'h5A, 4'b1000, "R7");
    step(1'b1, 8'h5A, 4'b1000, "R7");
    flush();

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule